// File: doc/BRIEF.md
# Programmable Priority Interrupt Arbiter

This block is the request arbiter of a vectored interrupt controller for a small processor core. Sixteen level-sensitive request lines, from external pins and on-chip modules, are sampled into a pending register each cycle. The sources are grouped in pairs. Each pair shares one 4-bit programmable priority field, so there are eight fields in all.

The arbiter resolves the pending set in three layers. The programmed field level decides first. Inside a field, a fixed sub-order applies. Between fields that hold the same level, a fixed default order applies. The winner is accepted only when its level is above the core's current mask level. On acceptance the block raises a one-cycle strobe and presents a unique vector number for the source. It also presents the accepted level, which the core loads into its mask.

Priority fields are written through a single-cycle write port that carries a field index and a level. Vector-table fetch and the core's exception sequencing are handled outside this block.

Top module: `irq_prio_arb`

## Requirements
- R1: After reset every priority field holds level 0 and accept_o is low, so no request is accepted until a field is written.
- R2: A cycle with cfg_we_i high sets field cfg_field_i (sources 2f and 2f+1) to cfg_level_i, and the next arbitration uses the new level; fields not written keep their level.
- R3: A source whose field holds level 0 is never accepted.
- R4: A winner is accepted only when its level is strictly greater than mask_lvl_i.
- R5: Among pending enabled sources, one whose field has a higher level beats one with a lower level.
- R6: When both sources of one field are pending, the even-indexed source (2f) wins over the odd one (2f+1).
- R7: When sources in different fields have equal levels, the lower source index wins.
- R8: On acceptance vector_o equals 64 plus the winning source index, and level_o equals the winner's programmed level.
- R9: A request held at clock edge N is accepted at edge N+1. accept_o is never high in two consecutive cycles.
- R10: Requests are level-sensitive. A pulse that is not present at an edge is never accepted. A pending request that is refused keeps competing and is accepted once the mask level falls below its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_req_i | input | 16 | Level-sensitive request lines, index = source number |
| mask_lvl_i | input | 4 | Current interrupt mask level of the core |
| cfg_we_i | input | 1 | Priority field write enable |
| cfg_field_i | input | 3 | Index of the field to write |
| cfg_level_i | input | 4 | Level to write |
| accept_o | output | 1 | One-cycle acceptance strobe |
| vector_o | output | 8 | Vector number of the accepted source |
| level_o | output | 4 | Accepted level, to be loaded into the core mask |

## Verification
Directed cases cover several distinct patterns. Two sources in one field at once separate the fixed sub-order from the default order. Equal levels in two fields separate the default order from level comparison. A raised level checks that programming overrides index order. A mask one step at and one step below the level pins down the strict comparison. Held requests under a high mask, followed by a mask drop, show that refused requests keep competing, and a short pulse between edges shows that it is never captured. Random field levels, request sets and masks are then compared against a bench model that applies the three ordering rules directly.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W = 4;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
  import irq_arb_pkg::*;
#(
  parameter int NUM_FIELDS = 8,
  parameter int FIELD_W    = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [FIELD_W-1:0]          field_i,
  input  lvl_t                        level_i,
  output logic [NUM_FIELDS-1:0][LVL_W-1:0] lvl_o
);
  logic [NUM_FIELDS-1:0][LVL_W-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
    end else if (we_i && (int'(field_i) < NUM_FIELDS)) begin
      lvl_q[field_i] <= level_i;
    end
  end

  assign lvl_o = lvl_q;

  // R2
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(we_i) |-> $stable(lvl_q));
endmodule

// File: rtl/irq_field_pick.sv
module irq_field_pick
  import irq_arb_pkg::*;
#(
  parameter int SPF   = 2,
  parameter int SUB_W = 1
) (
  input  logic [SPF-1:0]   pend_i,
  input  lvl_t             level_i,
  output logic             hit_o,
  output logic [SUB_W-1:0] sub_o
);
  // lowest index inside the field wins
  always_comb begin
    sub_o = '0;
    for (int i = SPF - 1; i >= 0; i--) begin
      if (pend_i[i]) sub_o = SUB_W'(i);
    end
  end

  // level 0 disables the whole field
  assign hit_o = (|pend_i) && (level_i != '0);
endmodule

// File: rtl/irq_level_tree.sv
module irq_level_tree
  import irq_arb_pkg::*;
#(
  parameter int NUM_FIELDS = 8,
  parameter int FIELD_W    = 3,
  parameter int SUB_W      = 1
) (
  input  logic [NUM_FIELDS-1:0][LVL_W-1:0] lvl_i,
  input  logic [NUM_FIELDS-1:0]            hit_i,
  input  logic [NUM_FIELDS-1:0][SUB_W-1:0] sub_i,
  output logic                             valid_o,
  output logic [FIELD_W-1:0]               field_o,
  output logic [SUB_W-1:0]                 sub_o,
  output lvl_t                             lvl_o
);
  // scan downward with >= so the lower field wins equal levels
  always_comb begin
    valid_o = 1'b0;
    field_o = '0;
    sub_o   = '0;
    lvl_o   = '0;
    for (int f = NUM_FIELDS - 1; f >= 0; f--) begin
      if (hit_i[f] && (!valid_o || lvl_i[f] >= lvl_o)) begin
        valid_o = 1'b1;
        field_o = FIELD_W'(f);
        sub_o   = sub_i[f];
        lvl_o   = lvl_i[f];
      end
    end
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC  = 16,
  parameter int SPF      = 2,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  localparam int NUM_FIELDS = NUM_SRC / SPF,
  localparam int FIELD_W    = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1,
  localparam int SUB_W      = (SPF > 1) ? $clog2(SPF) : 1,
  localparam int SRC_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_req_i,
  input  logic [LVL_W-1:0]   mask_lvl_i,
  input  logic               cfg_we_i,
  input  logic [FIELD_W-1:0] cfg_field_i,
  input  logic [LVL_W-1:0]   cfg_level_i,
  output logic               accept_o,
  output logic [VEC_W-1:0]   vector_o,
  output logic [LVL_W-1:0]   level_o
);
  logic [NUM_SRC-1:0]                pend_q;
  logic [NUM_FIELDS-1:0][LVL_W-1:0]  lvl;
  logic [NUM_FIELDS-1:0]             hit;
  logic [NUM_FIELDS-1:0][SUB_W-1:0]  sub;
  logic                              win_v;
  logic [FIELD_W-1:0]                win_f;
  logic [SUB_W-1:0]                  win_s;
  lvl_t                              win_l;
  logic [SRC_W-1:0]                  win_idx;
  logic                              take;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= irq_req_i;
  end

  irq_prio_regs #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .field_i (cfg_field_i),
    .level_i (cfg_level_i),
    .lvl_o   (lvl)
  );

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    irq_field_pick #(.SPF(SPF), .SUB_W(SUB_W)) u_pick (
      .pend_i  (pend_q[f*SPF +: SPF]),
      .level_i (lvl[f]),
      .hit_o   (hit[f]),
      .sub_o   (sub[f])
    );
  end

  irq_level_tree #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W), .SUB_W(SUB_W)) u_tree (
    .lvl_i   (lvl),
    .hit_i   (hit),
    .sub_i   (sub),
    .valid_o (win_v),
    .field_o (win_f),
    .sub_o   (win_s),
    .lvl_o   (win_l)
  );

  assign win_idx = SRC_W'(int'(win_f) * SPF + int'(win_s));
  // one idle cycle after each accept lets the core raise its mask
  assign take    = win_v && (win_l > mask_lvl_i) && !accept_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o <= 1'b0;
      vector_o <= '0;
      level_o  <= '0;
    end else begin
      accept_o <= take;
      if (take) begin
        vector_o <= VEC_W'(VEC_BASE) + VEC_W'(win_idx);
        level_o  <= win_l;
      end
    end
  end

  logic [NUM_SRC-1:0] pend_prev;
  logic [SRC_W-1:0]   acc_src;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_prev <= '0;
    else         pend_prev <= pend_q;
  end
  assign acc_src = SRC_W'(vector_o - VEC_W'(VEC_BASE));

  // R9
  accept_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !accept_o);
  // R4
  above_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (level_o > $past(mask_lvl_i)));
  // R3
  nonzero_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (level_o != '0));
  // R10
  was_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> pend_prev[acc_src]);
endmodule

// File: tb/irq_prio_arb_test.sv
`timescale 1ns/1ps
module irq_prio_arb_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req = '0;
  logic [3:0]  mask = '0;
  logic        we = 1'b0;
  logic [2:0]  fld = '0;
  logic [3:0]  wl = '0;
  logic        acc;
  logic [7:0]  vec;
  logic [3:0]  lvo;

  int n_run = 0;
  int n_fail = 0;
  int lv [8];

  always #2 clk = ~clk;

  irq_prio_arb uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req), .mask_lvl_i(mask),
    .cfg_we_i(we), .cfg_field_i(fld), .cfg_level_i(wl),
    .accept_o(acc), .vector_o(vec), .level_o(lvo)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic void model(input logic [15:0] r, input logic [3:0] m,
                                output bit v, output int idx, output int l);
    int best = -1;
    int bl = 0;
    for (int s = 0; s < 16; s++) begin
      if (r[s] && lv[s/2] != 0 && lv[s/2] > bl) begin
        best = s;
        bl = lv[s/2];
      end
    end
    v = (best >= 0) && (bl > int'(m));
    idx = best;
    l = bl;
  endfunction

  task automatic wr(input int f, input int l);
    @(negedge clk);
    we = 1'b1; fld = 3'(f); wl = 4'(l);
    @(negedge clk);
    we = 1'b0;
    lv[f] = l;
  endtask

  task automatic quiet();
    @(negedge clk);
    req = '0;
    repeat (3) @(negedge clk);
  endtask

  // drive, then check accept at edge N+1, the gap after it and the re-accept
  task automatic run_case(input logic [15:0] r, input logic [3:0] m, input string tag);
    bit v; int idx; int l;
    quiet();
    req = r; mask = m;
    model(r, m, v, idx, l);
    @(negedge clk);
    chk(acc == 1'b0, "R9 latency", int'(acc), 0);
    @(negedge clk);
    chk(acc == v, {tag, " accept"}, int'(acc), int'(v));
    if (v) begin
      chk(int'(vec) == 64 + idx, {tag, " R8 vector"}, int'(vec), 64 + idx);
      chk(int'(lvo) == l, {tag, " R8 level"}, int'(lvo), l);
      @(negedge clk);
      chk(acc == 1'b0, "R9 gap", int'(acc), 0);
      @(negedge clk);
      chk(acc == 1'b1, "R10 still pending", int'(acc), 1);
    end
    req = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    for (int i = 0; i < 8; i++) lv[i] = 0;
    repeat (3) @(negedge clk);
    chk(acc == 1'b0, "R1 reset accept", int'(acc), 0);
    rst_n = 1'b1;

    run_case(16'hFFFF, 4'd0, "R1 all zero levels");

    wr(3, 5); wr(5, 5);
    run_case(16'h0CC0, 4'd0, "R7 R6 tie");
    run_case(16'h0080, 4'd0, "R6 odd alone");
    run_case(16'h0C00, 4'd0, "R2 second field");
    run_case(16'h0040, 4'd5, "R4 equal mask");
    run_case(16'h0040, 4'd4, "R4 mask below");
    wr(5, 9);
    run_case(16'h0CC0, 4'd0, "R5 R2 higher level");
    wr(5, 0);
    run_case(16'h0400, 4'd0, "R3 disabled");
    run_case(16'h0440, 4'd0, "R3 other enabled");

    // R10 refused request keeps competing
    quiet();
    req = 16'h0040; mask = 4'd15;
    repeat (4) begin
      @(negedge clk);
      chk(acc == 1'b0, "R10 refused", int'(acc), 0);
    end
    mask = 4'd0;
    @(negedge clk);
    chk(acc == 1'b1 && vec == 8'd70, "R10 accepted after mask drop", int'(vec), 70);

    // R10 pulse between edges is never captured
    quiet();
    @(posedge clk); #0.5 req = 16'h0040; #1 req = '0;
    repeat (3) begin
      @(negedge clk);
      chk(acc == 1'b0, "R10 pulse ignored", int'(acc), 0);
    end

    for (int k = 0; k < 150; k++) begin
      if (k % 5 == 0) wr(int'($urandom_range(7, 0)), int'($urandom_range(15, 0)));
      run_case(16'($urandom), 4'($urandom_range(15, 0)), "R5 R7 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule